// File: doc/BRIEF.md
# Videophone Call Sequencer

This block runs one call on a telephone that carries voice and still pictures together. It watches a ring detector, an answer input, a line-drop input, a user capture button and an incoming-picture flag. From these it chooses between a live conversation and the unattended recorder. Inside a live call it also opens and closes the picture-send and picture-receive activities.

It drives level enables for the audio path, the recorder path, the camera, the picture transmitter and the picture receiver/display/store chain. It also drives a 4-bit state code. Send and receive are independent. They may overlap, and a dedicated state shows the overlap. Every call, answered or not, ends in a hang-up state and then returns to idle. All control pins are plain levels, and no pin carries a data stream, so there is no valid/ready handshake.

The ring, answer, line-drop, picture-present and done inputs must be synchronous to the clock. Only the capture button is synchronized inside the block.

Top module: `vpc_call_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle) and every path enable is low.
- R2: In idle, a rising edge on `ring_i` moves the state to ringing (code 1) on the next clock.
- R3: In ringing, `answer_i` high moves the state to conversation (code 2) on the next clock, with only `audio_en_o` high. Answer wins over a no-answer decision that falls in the same cycle.
- R4: If no answer arrives, the falling edge of ring burst number RINGS_TO_ANSWER (default 4, counted from the burst that left idle) moves the state to recorder (code 3), with only `recorder_en_o` high.
- R5: The capture button passes a two-stage synchronizer and an edge detector. A press that is high before clock edge k in a conversation state (codes 2, 5, 7) enters send-active (code 4) after edge k+2. A held button starts only one send. Presses in idle, ringing, recorder or an already-active send have no effect.
- R6: While send is active (codes 4 or 8), `cam_en_o` and `tx_en_o` stay high until `img_out_done_i` is seen. Code 4 with done then moves to send-closing (code 5), which lasts one cycle and then returns to code 2.
- R7: In a conversation state, `img_in_present_i` moves the state to receive-active (code 6) with `rx_en_o` high. `rx_en_o` stays high until `img_in_done_i`. Code 6 with done moves to receive-closing (code 7), which lasts one cycle and then returns to code 2.
- R8: Send and receive together give code 8, with `cam_en_o`, `tx_en_o`, `rx_en_o` and `audio_en_o` all high. A done for one side leaves the other side's single-activity state (out done gives 6, in done gives 4). Both done together give 2.
- R9: `line_drop_i` high forces hang-up (code 9) on the next clock from any state, with every enable low. Hang-up holds while the drop stays high. The first clock after the drop goes low returns the state to idle.
- R10: `audio_en_o` is high in codes 2 and 4 to 8. `audio_en_o` and `recorder_en_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_i | input | 1 | Ring detect level; each high burst is one ring cycle |
| answer_i | input | 1 | User went off-hook |
| line_drop_i | input | 1 | Hang-up or line loss; highest priority |
| capture_btn_i | input | 1 | Raw capture button, asynchronous |
| img_in_present_i | input | 1 | An incoming picture has started |
| img_out_done_i | input | 1 | Camera capture and transmit have finished |
| img_in_done_i | input | 1 | Incoming picture fully received and stored |
| audio_en_o | output | 1 | Live audio path enable |
| recorder_en_o | output | 1 | Answering-recorder path enable |
| cam_en_o | output | 1 | Camera capture enable |
| tx_en_o | output | 1 | Picture transmit enable |
| rx_en_o | output | 1 | Picture receive/display/store enable |
| state_o | output | 4 | Current state code |

## Verification
Every state change takes effect at the first clock edge after the cause is applied. The enables are decoded directly from the state register, so they change at that same edge. The capture button is the exception: it lands two edges later than the other inputs, because of the synchronizer and the edge register. The bench changes inputs on the falling clock edge and checks state and enables on the following falling edge, one rising edge later. For button presses it checks the unchanged state after the second edge and the new state after the third.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RING    = 4'd1,
    ST_TALK    = 4'd2,
    ST_RECORD  = 4'd3,
    ST_OUT_ON  = 4'd4,
    ST_OUT_OFF = 4'd5,
    ST_IN_ON   = 4'd6,
    ST_IN_OFF  = 4'd7,
    ST_INOUT   = 4'd8,
    ST_HANGUP  = 4'd9
  } call_state_e;
endpackage

// File: rtl/vpc_btn_edge.sv
module vpc_btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pulse_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R5: one press gives a single-cycle pulse
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/vpc_ring_count.sv
module vpc_ring_count #(
  parameter int RINGS_TO_ANSWER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_i,
  input  logic in_idle_i,
  input  logic in_ring_i,
  output logic rise_o,
  output logic fall_o,
  output logic limit_o
);
  localparam int CW = $clog2(RINGS_TO_ANSWER + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RINGS_TO_ANSWER);

  logic          ring_q;
  logic [CW-1:0] cnt_q;

  assign rise_o  = ring_i & ~ring_q;
  assign fall_o  = ~ring_i & ring_q;
  assign limit_o = (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ring_q <= ring_i;
      if (in_ring_i) begin
        if (rise_o && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end else if (in_idle_i && rise_o) begin
        cnt_q <= CW'(1);
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R4: the ring count never passes its limit
  p_cnt_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/vpc_call_fsm.sv
module vpc_call_fsm
  import vpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drop_i,
  input  logic        ring_rise_i,
  input  logic        ring_fall_i,
  input  logic        ring_limit_i,
  input  logic        answer_i,
  input  logic        cap_i,
  input  logic        present_i,
  input  logic        out_done_i,
  input  logic        in_done_i,
  output call_state_e state_o
);
  call_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (drop_i) begin
      st_d = ST_HANGUP;
    end else begin
      unique case (st_q)
        ST_IDLE:   if (ring_rise_i) st_d = ST_RING;
        ST_RING: begin
          if (answer_i) st_d = ST_TALK;
          else if (ring_fall_i && ring_limit_i) st_d = ST_RECORD;
        end
        ST_RECORD: st_d = ST_RECORD;
        ST_TALK, ST_OUT_OFF, ST_IN_OFF: begin
          if (cap_i && present_i) st_d = ST_INOUT;
          else if (cap_i)         st_d = ST_OUT_ON;
          else if (present_i)     st_d = ST_IN_ON;
          else                    st_d = ST_TALK;
        end
        ST_OUT_ON: begin
          if (out_done_i) st_d = present_i ? ST_IN_ON : ST_OUT_OFF;
          else if (present_i) st_d = ST_INOUT;
        end
        ST_IN_ON: begin
          if (in_done_i) st_d = cap_i ? ST_OUT_ON : ST_IN_OFF;
          else if (cap_i) st_d = ST_INOUT;
        end
        ST_INOUT: begin
          if (out_done_i && in_done_i) st_d = ST_TALK;
          else if (out_done_i)         st_d = ST_IN_ON;
          else if (in_done_i)          st_d = ST_OUT_ON;
        end
        ST_HANGUP: st_d = ST_IDLE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R9: line drop wins from every state
  p_drop_hangup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> st_q == ST_HANGUP);
  p_hangup_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HANGUP && !drop_i) |=> st_q == ST_IDLE);
  // R2: ring edge leaves idle
  p_ring_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && ring_rise_i && !drop_i) |=> st_q == ST_RING);
  // R3: answer leads to conversation
  p_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RING && answer_i && !drop_i) |=> st_q == ST_TALK);
endmodule

// File: rtl/vpc_call_ctrl.sv
module vpc_call_ctrl
  import vpc_pkg::*;
#(
  parameter int RINGS_TO_ANSWER = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ring_i,
  input  logic       answer_i,
  input  logic       line_drop_i,
  input  logic       capture_btn_i,
  input  logic       img_in_present_i,
  input  logic       img_out_done_i,
  input  logic       img_in_done_i,
  output logic       audio_en_o,
  output logic       recorder_en_o,
  output logic       cam_en_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic [3:0] state_o
);
  call_state_e st;
  logic cap_pulse, ring_rise, ring_fall, ring_limit;

  vpc_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_i(capture_btn_i), .pulse_o(cap_pulse)
  );

  vpc_ring_count #(.RINGS_TO_ANSWER(RINGS_TO_ANSWER)) u_ring (
    .clk(clk), .rst_n(rst_n), .ring_i(ring_i),
    .in_idle_i(st == ST_IDLE), .in_ring_i(st == ST_RING),
    .rise_o(ring_rise), .fall_o(ring_fall), .limit_o(ring_limit)
  );

  vpc_call_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .drop_i(line_drop_i),
    .ring_rise_i(ring_rise), .ring_fall_i(ring_fall), .ring_limit_i(ring_limit),
    .answer_i(answer_i), .cap_i(cap_pulse), .present_i(img_in_present_i),
    .out_done_i(img_out_done_i), .in_done_i(img_in_done_i), .state_o(st)
  );

  logic send_act;
  always_comb begin
    send_act      = (st == ST_OUT_ON) || (st == ST_INOUT);
    audio_en_o    = (st == ST_TALK) || (st == ST_OUT_ON) || (st == ST_OUT_OFF) ||
                    (st == ST_IN_ON) || (st == ST_IN_OFF) || (st == ST_INOUT);
    recorder_en_o = (st == ST_RECORD);
    cam_en_o      = send_act;
    tx_en_o       = send_act;
    rx_en_o       = (st == ST_IN_ON) || (st == ST_INOUT);
  end

  assign state_o = st;

  // R6: send enables hold until done
  p_send_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cam_en_o && !img_out_done_i && !line_drop_i) |=> (cam_en_o && tx_en_o));
  // R7: receive enable holds until done
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_o && !img_in_done_i && !line_drop_i) |=> rx_en_o);
  // R10: live audio and recorder are exclusive
  p_paths_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(audio_en_o && recorder_en_o));
  // R9: all paths closed the cycle after a drop
  p_drop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_drop_i |=> !(audio_en_o || recorder_en_o || cam_en_o || rx_en_o));
endmodule

// File: tb/vpc_call_ctrl_test.sv
module vpc_call_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring, ans, drop, btn, pres, odone, idone;
  logic audio_en, rec_en, cam_en, tx_en, rx_en;
  logic [3:0] state;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpc_call_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ring_i(ring), .answer_i(ans), .line_drop_i(drop),
    .capture_btn_i(btn), .img_in_present_i(pres), .img_out_done_i(odone),
    .img_in_done_i(idone), .audio_en_o(audio_en), .recorder_en_o(rec_en),
    .cam_en_o(cam_en), .tx_en_o(tx_en), .rx_en_o(rx_en), .state_o(state)
  );

  // fields: btn ring ans drop pres odone idone | expected state
  localparam logic [10:0] VEC [NVEC] = '{
    {7'b0100000, 4'd1}, {7'b0000000, 4'd1}, {7'b0100000, 4'd1}, {7'b0000000, 4'd1},
    {7'b0110000, 4'd2}, {7'b0000000, 4'd2}, {7'b0000100, 4'd6}, {7'b0000100, 4'd6},
    {7'b0000001, 4'd7}, {7'b0000000, 4'd2}, {7'b0001000, 4'd9}, {7'b0000000, 4'd0},
    {7'b0100000, 4'd1}, {7'b0000000, 4'd1}, {7'b0100000, 4'd1}, {7'b0000000, 4'd1},
    {7'b0100000, 4'd1}, {7'b0000000, 4'd1}, {7'b0100000, 4'd1}, {7'b0000000, 4'd3},
    {7'b1000000, 4'd3}, {7'b0000000, 4'd3}, {7'b0000000, 4'd3}, {7'b0001000, 4'd9},
    {7'b0001000, 4'd9}, {7'b0000000, 4'd0}
  };

  function automatic logic [4:0] exp_outs(input logic [3:0] s);
    logic a, r, snd, rx;
    a   = (s == 4'd2) || (s >= 4'd4 && s <= 4'd8);
    r   = (s == 4'd3);
    snd = (s == 4'd4) || (s == 4'd8);
    rx  = (s == 4'd6) || (s == 4'd8);
    return {a, r, snd, snd, rx};
  endfunction

  task automatic chk(input string tag, input logic [3:0] exp_st);
    logic [8:0] got, exp;
    got = {state, audio_en, rec_en, cam_en, tx_en, rx_en};
    exp = {exp_st, exp_outs(exp_st)};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual state/outs=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idle_in();
    {btn, ring, ans, drop, pres, odone, idone} = 7'b0;
  endtask

  task automatic go_talk();
    ring = 1'b1; cyc();
    ring = 1'b0; ans = 1'b1; cyc();
    ans = 1'b0;
    chk("R3 enter talk", 4'd2);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    chk("R1 reset state", 4'd0);
    rst_n = 1'b1;
    cyc();
    chk("R1 idle after reset", 4'd0);

    // table: R2 R3 R4 R7 R9, and R5 press ignored in recorder
    for (int i = 0; i < NVEC; i++) begin
      {btn, ring, ans, drop, pres, odone, idone} = VEC[i][10:4];
      cyc();
      chk($sformatf("R2/R3/R4/R7/R9/R10 row %0d", i), VEC[i][3:0]);
    end
    idle_in();

    // R5 capture latency, R6 hold, single send per press
    go_talk();
    btn = 1'b1;
    cyc(2);
    chk("R5 sync latency", 4'd2);
    cyc();
    chk("R5 send started", 4'd4);
    cyc(3);
    chk("R6 send held without done", 4'd4);
    odone = 1'b1; cyc(); odone = 1'b0;
    chk("R6 send closing", 4'd5);
    cyc();
    chk("R6 back to talk", 4'd2);
    cyc(4);
    chk("R5 held button no second send", 4'd2);
    btn = 1'b0; cyc(3);

    // R8 overlap, out done first
    pres = 1'b1; cyc();
    chk("R7 receive start", 4'd6);
    btn = 1'b1; cyc(3);
    chk("R8 both active", 4'd8);
    btn = 1'b0; odone = 1'b1; cyc(); odone = 1'b0;
    chk("R8 out done leaves receive", 4'd6);
    pres = 1'b0; idone = 1'b1; cyc(); idone = 1'b0;
    chk("R7 receive closing", 4'd7);
    cyc();
    chk("R7 back to talk", 4'd2);

    // R8 both done together
    pres = 1'b1; btn = 1'b1; cyc(3);
    chk("R8 press plus picture", 4'd8);
    btn = 1'b0; pres = 1'b0; odone = 1'b1; idone = 1'b1; cyc();
    odone = 1'b0; idone = 1'b0;
    chk("R8 both done", 4'd2);

    // R8 in done first
    pres = 1'b1; btn = 1'b1; cyc(3);
    btn = 1'b0; pres = 1'b0; idone = 1'b1; cyc(); idone = 1'b0;
    chk("R8 in done leaves send", 4'd4);
    // R9 drop during send
    drop = 1'b1; cyc(); drop = 1'b0;
    chk("R9 drop during send", 4'd9);
    cyc();
    chk("R9 idle after drop", 4'd0);

    // R4 boundary: answer in the same cycle as the limit fall
    for (int k = 0; k < 3; k++) begin
      ring = 1'b1; cyc(); ring = 1'b0; cyc();
    end
    ring = 1'b1; cyc();
    chk("R4 still ringing on last burst", 4'd1);
    ring = 1'b0; ans = 1'b1; cyc(); ans = 1'b0;
    chk("R3 answer beats limit R4", 4'd2);

    // R5 press in idle ignored
    drop = 1'b1; cyc(); drop = 1'b0; cyc();
    btn = 1'b1; cyc(4); btn = 1'b0; cyc(2);
    chk("R5 press in idle ignored", 4'd0);

    // R1 reset mid-call
    go_talk();
    pres = 1'b1; cyc(); pres = 1'b0;
    rst_n = 1'b0; cyc();
    chk("R1 reset mid-call", 4'd0);
    rst_n = 1'b1; cyc();
    chk("R1 idle after release", 4'd0);

    finish_run();
  end
endmodule